// File: doc/BRIEF.md
# Self-Checking Parity-Predicted Adder

This block is a registered adder that checks itself. Two operands, each with a parity bit, and a carry-in are captured in input registers. A parallel-prefix carry network of the Brent-Kung kind produces the carries, and the sum is formed from them. A second carry chain is built separately as a plain ripple. It does not share a gate with the prefix network.

The checker predicts the parity of the sum from the operand parity bits and the redundant carries. It compares that prediction with the parity of the sum the main network actually formed. It also compares the two carry vectors bit by bit, and it re-checks the parity of the registered operands. Any mismatch sets an error flag. The flag is registered in the same cycle as the result, so each result leaves the block together with its own verdict.

A single fault in the operand registers or in the adder logic therefore gives either a correct output or a raised flag. The consumer treats a raised flag as a request to discard or recompute the result. The block does not correct errors.

Top module: `parity_adder`

## Requirements
- R1: `{carry_out, sum_out}` equals `op_a + op_b + carry_in`, taken from the inputs present two rising clock edges earlier (one input register stage, one output register stage).
- R2: When `err_flag` is low, `out_par` equals the XOR of `carry_out` and all bits of `sum_out`, so the output word {carry_out, sum_out, out_par} has even parity.
- R3: Operand parity is even. `op_a_par` covers `op_a` together with `carry_in`: the XOR of {carry_in, op_a, op_a_par} must be 0. `op_b_par` covers `op_b`: the XOR of {op_b, op_b_par} must be 0. A violation of either rule sets `err_flag` with the same two-edge latency as the sum, and the sum is still the arithmetic result.
- R4: With correctly encoded operands and no internal fault, `err_flag` stays low for every value of op_a, op_b and carry_in.
- R5: Inverting any one of the main network's carries c1..cWIDTH (carry into bit i, and cWIDTH being carry-out) while a result is being formed sets `err_flag` for that result.
- R6: Inverting any one of the redundant chain's carries c1..cWIDTH sets `err_flag` for that result.
- R7: Inverting any one bit of the sum before the output register sets `err_flag` for that result.
- R8: Inverting any one bit of the registered operand A sets `err_flag` for that result.
- R9: Driving `rst_n` low clears `sum_out`, `carry_out`, `out_par` and `err_flag` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | WIDTH | Operand A |
| op_a_par | input | 1 | Even parity bit over op_a and carry_in |
| op_b | input | WIDTH | Operand B |
| op_b_par | input | 1 | Even parity bit over op_b |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Registered sum |
| carry_out | output | 1 | Registered carry-out |
| out_par | output | 1 | Predicted parity of {carry_out, sum_out} |
| err_flag | output | 1 | Registered error verdict for the result beside it |

## Verification
Operands are taken in at one rising edge. The sum, carry-out, output parity and error flag all appear after the second rising edge. The bench therefore queues the expected values for each applied input and compares them two falling edges later, which is one half-cycle after the output register has loaded. For fault injection, the bench holds the operands until the input register has loaded them. It then forces one node during the cycle that ends at the output register, and reads the flag at the falling edge that follows. The reset clear is checked one nanosecond after `rst_n` falls in the middle of a clock period, so it does not rely on any clock edge.

// File: rtl/pa_pkg.sv
package pa_pkg;

  // Generate/propagate pair for one prefix group.
  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // Merge a more-significant group with the group just below it.
  function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

endpackage

// File: rtl/pa_bk_carry.sv
module pa_bk_carry
  import pa_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH:0]   carry
);

  localparam int LOGW = $clog2(WIDTH);
  localparam int NSTG = 2 * LOGW - 1;

  gp_t stg [0:NSTG][0:WIDTH-1];

  // Stage 0: bit-level generate/propagate, with carry-in folded into bit 0.
  for (genvar i = 0; i < WIDTH; i++) begin : g_leaf
    if (i == 0) begin : g_lsb
      assign stg[0][i] = '{g: (a[0] & b[0]) | ((a[0] ^ b[0]) & cin), p: 1'b0};
    end else begin : g_oth
      assign stg[0][i] = '{g: a[i] & b[i], p: a[i] ^ b[i]};
    end
  end

  // Up-sweep levels, then down-sweep levels.
  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (s < LOGW) begin : g_up
        localparam int D = 1 << s;
        if (((i + 1) % (2 * D)) == 0) begin : g_node
          assign stg[s+1][i] = gp_merge(stg[s][i], stg[s][i-D]);
        end else begin : g_pass
          assign stg[s+1][i] = stg[s][i];
        end
      end else begin : g_dn
        localparam int D = 1 << (NSTG - 1 - s);
        if ((((i + 1) % (2 * D)) == D) && (i >= 2 * D)) begin : g_node
          assign stg[s+1][i] = gp_merge(stg[s][i], stg[s][i-D]);
        end else begin : g_pass
          assign stg[s+1][i] = stg[s][i];
        end
      end
    end
  end

  assign carry[0] = cin;
  for (genvar i = 0; i < WIDTH; i++) begin : g_cout
    assign carry[i+1] = stg[NSTG][i].g;
  end

endmodule

// File: rtl/pa_ripple_carry.sv
module pa_ripple_carry #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH:0]   carry
);

  // Independent majority-form ripple; shares no gate with the prefix tree.
  assign carry[0] = cin;
  for (genvar i = 0; i < WIDTH; i++) begin : g_rip
    assign carry[i+1] = (a[i] & b[i]) | ((a[i] | b[i]) & carry[i]);
  end

endmodule

// File: rtl/pa_parity_check.sv
module pa_parity_check #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  input  logic             a_par,
  input  logic             b_par,
  input  logic [WIDTH:0]   main_carry,
  input  logic [WIDTH:0]   red_carry,
  input  logic [WIDTH-1:0] sum,
  output logic             word_par,
  output logic             err
);

  logic in_bad;
  logic pred_sum_par;
  logic sum_bad;
  logic carry_bad;

  always_comb begin
    // Operand parity: A word includes the carry-in.
    in_bad       = (^{cin, a, a_par}) | (^{b, b_par});
    // Sum parity = par(A) ^ par(B) ^ par(c0..c(W-1)); c0 is already in a_par.
    pred_sum_par = a_par ^ b_par ^ (^red_carry[WIDTH-1:1]);
    sum_bad      = (^sum) ^ pred_sum_par;
    carry_bad    = |(main_carry[WIDTH:1] ^ red_carry[WIDTH:1]);
    word_par     = pred_sum_par ^ red_carry[WIDTH];
    err          = in_bad | sum_bad | carry_bad;
  end

endmodule

// File: rtl/parity_adder.sv
module parity_adder #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic             op_a_par,
  input  logic [WIDTH-1:0] op_b,
  input  logic             op_b_par,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out,
  output logic             out_par,
  output logic             err_flag
);

  // Input register stage
  logic [WIDTH-1:0] a_q;
  logic [WIDTH-1:0] b_q;
  logic             cin_q;
  logic             pa_q;
  logic             pb_q;

  // Combinational result and verdict
  logic [WIDTH:0]   main_carry;
  logic [WIDTH:0]   red_carry;
  logic [WIDTH-1:0] sum_d;
  logic             word_par_d;
  logic             err_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      cin_q <= 1'b0;
      pa_q  <= 1'b0;
      pb_q  <= 1'b0;
    end else begin
      a_q   <= op_a;
      b_q   <= op_b;
      cin_q <= carry_in;
      pa_q  <= op_a_par;
      pb_q  <= op_b_par;
    end
  end

  pa_bk_carry #(.WIDTH(WIDTH)) u_bk (
    .a     (a_q),
    .b     (b_q),
    .cin   (cin_q),
    .carry (main_carry)
  );

  pa_ripple_carry #(.WIDTH(WIDTH)) u_rip (
    .a     (a_q),
    .b     (b_q),
    .cin   (cin_q),
    .carry (red_carry)
  );

  always_comb begin
    sum_d = a_q ^ b_q ^ main_carry[WIDTH-1:0];
  end

  pa_parity_check #(.WIDTH(WIDTH)) u_chk (
    .a          (a_q),
    .b          (b_q),
    .cin        (cin_q),
    .a_par      (pa_q),
    .b_par      (pb_q),
    .main_carry (main_carry),
    .red_carry  (red_carry),
    .sum        (sum_d),
    .word_par   (word_par_d),
    .err        (err_d)
  );

  // Output register stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_out   <= '0;
      carry_out <= 1'b0;
      out_par   <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      sum_out   <= sum_d;
      carry_out <= main_carry[WIDTH];
      out_par   <= word_par_d;
      err_flag  <= err_d;
    end
  end

endmodule

// File: rtl/pa_sva.sv
module pa_sva #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] op_a,
  input logic             op_a_par,
  input logic [WIDTH-1:0] op_b,
  input logic             op_b_par,
  input logic             carry_in,
  input logic [WIDTH-1:0] sum_out,
  input logic             carry_out,
  input logic             out_par,
  input logic             err_flag
);

  logic [1:0]     cyc;
  logic [WIDTH:0] ref_sum;
  logic           in_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 2'd0;
    else if (cyc != 2'd2) cyc <= cyc + 2'd1;
  end

  assign ref_sum = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
  assign in_bad  = (^{carry_in, op_a, op_a_par}) | (^{op_b, op_b_par});

  assert_sum_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd2 && !err_flag) |-> ({carry_out, sum_out} == $past(ref_sum, 2)));

  assert_word_parity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !err_flag |-> ((^{carry_out, sum_out, out_par}) == 1'b0));

  assert_bad_operand_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd2 && $past(in_bad, 2)) |-> err_flag);

  assert_reset_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sum_out == '0 && !carry_out && !out_par && !err_flag));

endmodule

bind parity_adder pa_sva #(.WIDTH(WIDTH)) u_pa_sva (.*);

// File: tb/parity_adder_bench.sv
module parity_adder_bench;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] op_a;
  logic         op_a_par;
  logic [W-1:0] op_b;
  logic         op_b_par;
  logic         carry_in;
  logic [W-1:0] sum_out;
  logic         carry_out;
  logic         out_par;
  logic         err_flag;

  int checks = 0;
  int fails  = 0;

  typedef struct packed {
    logic [W-1:0] sum;
    logic         cout;
    logic         par;
    logic         err;
  } exp_t;

  exp_t q[$];

  logic [W:0]   fv_c;
  logic [W-1:0] fv_s;

  always #5 clk = ~clk;

  parity_adder #(.WIDTH(W)) u_parity_adder (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_a      (op_a),
    .op_a_par  (op_a_par),
    .op_b      (op_b),
    .op_b_par  (op_b_par),
    .carry_in  (carry_in),
    .sum_out   (sum_out),
    .carry_out (carry_out),
    .out_par   (out_par),
    .err_flag  (err_flag)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", fails, checks);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W:0] carries(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic ci);
    logic [W:0] c;
    for (int i = 0; i <= W; i++) begin
      int m;
      m = 1 << i;
      c[i] = 1'(((int'(a) % m) + (int'(b) % m) + int'(ci)) >> i);
    end
    return c;
  endfunction

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic ci,
                       input logic bad_a, input logic bad_b);
    op_a     = a;
    op_b     = b;
    carry_in = ci;
    op_a_par = (^{ci, a}) ^ bad_a;
    op_b_par = (^b) ^ bad_b;
  endtask

  // One cycle: check the result due now, then apply and queue the next input.
  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b, input logic ci,
                      input logic bad_a, input logic bad_b);
    exp_t e;
    logic [W:0] t;
    @(negedge clk);
    if (q.size() == 2) begin
      e = q.pop_front();
      chk("R1 sum/carry", {27'd0, carry_out, sum_out}, {27'd0, e.cout, e.sum});
      if (e.err) chk("R3 err on bad operand parity", {31'd0, err_flag}, 32'd1);
      else begin
        chk("R4 err quiet on good operands", {31'd0, err_flag}, 32'd0);
        chk("R2 output word parity", {31'd0, out_par}, {31'd0, e.par});
      end
    end
    drive(a, b, ci, bad_a, bad_b);
    t = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
    e.sum  = t[W-1:0];
    e.cout = t[W];
    e.par  = ^t;
    e.err  = bad_a | bad_b;
    q.push_back(e);
  endtask

  // node 0: main carry (R5), 1: redundant carry (R6), 2: pre-register sum (R7),
  // 3: registered operand A (R8)
  task automatic inject(input int node, input int k, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic ci);
    logic [W:0] gc;
    logic [W:0] t;
    q.delete();
    gc = carries(a, b, ci);
    t  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
    @(negedge clk);
    drive(a, b, ci, 1'b0, 1'b0);
    @(negedge clk);
    case (node)
      0: begin fv_c = gc ^ ((W+1)'(1) << k); force u_parity_adder.main_carry = fv_c; end
      1: begin fv_c = gc ^ ((W+1)'(1) << k); force u_parity_adder.red_carry = fv_c; end
      2: begin fv_s = t[W-1:0] ^ (W'(1) << k); force u_parity_adder.sum_d = fv_s; end
      default: begin fv_s = a ^ (W'(1) << k); force u_parity_adder.a_q = fv_s; end
    endcase
    @(negedge clk);
    case (node)
      0: begin chk("R5 main carry fault flagged", {31'd0, err_flag}, 32'd1);
               release u_parity_adder.main_carry; end
      1: begin chk("R6 redundant carry fault flagged", {31'd0, err_flag}, 32'd1);
               release u_parity_adder.red_carry; end
      2: begin chk("R7 sum bit fault flagged", {31'd0, err_flag}, 32'd1);
               release u_parity_adder.sum_d; end
      default: begin chk("R8 operand register fault flagged", {31'd0, err_flag}, 32'd1);
               release u_parity_adder.a_q; end
    endcase
    q.delete();
  endtask

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive('0, '0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    // R9: outputs held clear in reset
    chk("R9 reset clears outputs", {27'd0, err_flag, out_par, carry_out, sum_out}, 32'd0);
    rst_n = 1'b1;

    // R1 R2 R4: every operand combination, good parity
    for (int ci = 0; ci < 2; ci++)
      for (int a = 0; a < (1 << W); a++)
        for (int b = 0; b < (1 << W); b++)
          step(W'(a), W'(b), 1'(ci), 1'b0, 1'b0);

    // R3: corrupted parity on A, B or both
    for (int i = 0; i < 24; i++)
      step(W'(i * 7 + 3), W'(i * 5 + 1), 1'(i >> 1), 1'(i % 3 != 1), 1'(i % 3 != 0));
    step(4'd9, 4'd6, 1'b1, 1'b0, 1'b0);
    step(4'd0, 4'd0, 1'b0, 1'b0, 1'b0);
    step(4'd0, 4'd0, 1'b0, 1'b0, 1'b0);

    // R5..R8: single-node fault injection
    for (int v = 0; v < 4; v++) begin
      logic [W-1:0] fa;
      logic [W-1:0] fb;
      logic         fc;
      fa = W'(v * 5 + 5);
      fb = W'(15 - v * 3);
      fc = 1'(v);
      for (int k = 1; k <= W; k++) inject(0, k, fa, fb, fc);
      for (int k = 1; k <= W; k++) inject(1, k, fa, fb, fc);
      for (int k = 0; k < W; k++)  inject(2, k, fa, fb, fc);
      for (int k = 0; k < W; k++)  inject(3, k, fa, fb, fc);
    end

    // Recovery after faults, then an asynchronous reset mid-period (R9)
    step(4'd15, 4'd15, 1'b0, 1'b0, 1'b0);
    step(4'd15, 4'd15, 1'b0, 1'b0, 1'b0);
    step(4'd15, 4'd15, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    chk("R9 async reset clears outputs",
        {27'd0, err_flag, out_par, carry_out, sum_out}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    q.delete();
    step(4'd3, 4'd12, 1'b1, 1'b0, 1'b0);
    step(4'd8, 4'd8, 1'b0, 1'b0, 1'b0);
    step(4'd0, 4'd0, 1'b0, 1'b0, 1'b0);
    step(4'd0, 4'd0, 1'b0, 1'b0, 1'b0);

    summary();
    $finish;
  end

endmodule